// File: doc/BRIEF.md
# Periodic Comparator Measurement Sequencer

This block schedules a shared analog level detector so that it compares one input pin against a fixed threshold at a steady rate. It runs on a slow base clock. It receives two single-cycle tick strobes from a free-running prescaler: a fast synchronisation tick and a slow measurement tick. Before the first measurement it waits for a synchronisation tick. It then opens one measurement window per group of measurement ticks. At the closing tick of each window it latches the comparator output into a result bit.

Software controls the sequencer through three inputs: a select bit that hands the detector to this function, an enable level and an interrupt mask. Clearing the enable does not stop the sequencer at once. The measurement in progress and one further measurement still complete, and only then does the busy flag drop. Each time a newly latched result differs from the previous one, the sequencer emits a one-cycle interrupt pulse. The first result after every fresh start never raises one.

Top module: `cmp_meas_seq`

## Requirements
- R1: After reset, `result`, `busy`, `det_window` and `irq` are all 0.
- R2: While idle, a start happens only in a cycle where `en` and `sel` are both 1, and `busy` reads 1 from the following cycle. With `sel` at 0, `busy` stays 0 and no window opens, whatever `en` and the ticks do.
- R3: After a start, measurement ticks are ignored until a `tick_sync` pulse arrives. `det_window` reads 1 from the cycle after that pulse, and the first result is latched at the next `tick_meas`.
- R4: After the first result, successive results are latched exactly GAP_TICKS `tick_meas` pulses apart. `det_window` is 1 only during the last of those tick intervals.
- R5: On a latching tick, `result` takes the value of `cmp_in` (1 = input below the threshold, 0 = above) and shows it from the next cycle. At all other times `result` holds.
- R6: While `en` is 0 and the sequencer is busy, the sequencer counts completed measurements. `busy` falls together with the update of `result` at the STOP_CYCLES-th completion. If `en` returns to 1 before that completion, the count restarts and the sequencer keeps running.
- R7: `irq` is a one-cycle pulse, visible in the same cycle as the updated `result`, raised when a latched value differs from the one before it. The first result after each start raises no pulse, including the first result after a restart from idle.
- R8: `irq_mask` (1 = masked) passes through a register that resets to masked. A pulse that falls due while masked is dropped, and it does not appear after unmasking.
- R9: While busy, changes of `sel` are ignored. `det_route` stays 1, and measurements continue on schedule.
- R10: While idle, `det_route` follows `sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sync | input | 1 | Single-cycle synchronisation strobe from the prescaler |
| tick_meas | input | 1 | Single-cycle measurement-period strobe from the prescaler |
| sel | input | 1 | 1 routes the detector to this comparator function |
| en | input | 1 | Measurement enable level |
| irq_mask | input | 1 | 1 suppresses interrupt pulses |
| cmp_in | input | 1 | Comparator output, 1 when the input is below the threshold |
| result | output | 1 | Last latched comparison |
| busy | output | 1 | Sequencer active, from start to the final measurement |
| det_route | output | 1 | Detector ownership: 1 = comparator, 0 = supply-level function |
| det_window | output | 1 | A measurement window is open |
| irq | output | 1 | One-cycle result-change interrupt pulse |

## Verification
The bench builds the block with its default parameters, GAP_TICKS = 3 and STOP_CYCLES = 2. Because the bench drives both tick strobes itself, a cycle or two of clock stands in for a full prescaler period. This lets every intermediate window position, the two-measurement stop and a cancelled stop all be reached in a few hundred clock cycles. With a gap of three ticks, the bench sees the window closed after the first gap tick and open after the second, so the exact position of the window is observed and not only the cadence of the results.

// File: rtl/cmp_seq_pkg.sv
package cmp_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_RUN  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/cmp_seq_rst_sync.sv
module cmp_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/cmp_seq_sched.sv
module cmp_seq_sched
  import cmp_seq_pkg::*;
#(
  parameter int GAP_TICKS   = 3,
  parameter int STOP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_sync,
  input  logic tick_meas,
  input  logic en,
  input  logic sel,
  output logic busy,
  output logic window,
  output logic start,
  output logic store
);

  localparam int CW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam int SW = $clog2(STOP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST  = CW'(GAP_TICKS - 1);
  localparam logic [SW-1:0] STOP_LOAD = SW'(STOP_CYCLES);

  seq_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [SW-1:0]  left_q, left_d;
  logic           final_done;

  // Decode of the current state
  always_comb begin
    start      = (state_q == ST_IDLE) && en && sel;
    window     = (state_q == ST_RUN) && (cnt_q == CNT_LAST);
    store      = window && tick_meas;
    final_done = store && !en && (left_q == SW'(1));
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SYNC;
          left_d  = STOP_LOAD;
        end
      end
      ST_SYNC: begin
        if (tick_sync) begin
          state_d = ST_RUN;
          cnt_d   = CNT_LAST;
        end
      end
      ST_RUN: begin
        if (tick_meas) begin
          cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_IDLE) begin
      if (en) begin
        left_d = STOP_LOAD;
      end else if (store) begin
        left_d = left_q - SW'(1);
      end
    end
    if (final_done) begin
      state_d = ST_IDLE;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  // Independent tick counter kept for the spacing check
  logic [CW:0] gap_seen_q;
  logic        had_store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_seen_q  <= '0;
      had_store_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      gap_seen_q  <= '0;
      had_store_q <= 1'b0;
    end else if (store) begin
      gap_seen_q  <= '0;
      had_store_q <= 1'b1;
    end else if (tick_meas && (state_q == ST_RUN)) begin
      gap_seen_q  <= gap_seen_q + (CW+1)'(1);
    end
  end

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && sel));

  assert_sync_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && ($past(state_q) == ST_SYNC) |-> $past(tick_sync));

  assert_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    store && had_store_q |-> (gap_seen_q == (CW+1)'(GAP_TICKS - 1)));

  assert_stop_on_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(store && !en));

endmodule

// File: rtl/cmp_seq_result.sv
module cmp_seq_result (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic store,
  input  logic cmp_in,
  input  logic irq_mask,
  output logic result,
  output logic irq
);

  logic result_q, result_d;
  logic first_q, first_d;
  logic mask_q;
  logic irq_q, irq_d;
  logic changed;

  always_comb begin
    changed  = store && !first_q && (cmp_in != result_q);
    result_d = store ? cmp_in : result_q;
    irq_d    = changed && !mask_q;
    first_d  = first_q;
    if (start) begin
      first_d = 1'b1;
    end else if (store) begin
      first_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= 1'b0;
      first_q  <= 1'b0;
      mask_q   <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      result_q <= result_d;
      first_q  <= first_d;
      mask_q   <= irq_mask;
      irq_q    <= irq_d;
    end
  end

  assign result = result_q;
  assign irq    = irq_q;

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(store) |-> $stable(result));

  assert_irq_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (result != $past(result)));

  assert_first_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store && first_q |=> !irq);

  assert_mask_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(irq_mask, 2));

endmodule

// File: rtl/cmp_meas_seq.sv
module cmp_meas_seq #(
  parameter int GAP_TICKS   = 3,
  parameter int STOP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_sync,
  input  logic tick_meas,
  input  logic sel,
  input  logic en,
  input  logic irq_mask,
  input  logic cmp_in,
  output logic result,
  output logic busy,
  output logic det_route,
  output logic det_window,
  output logic irq
);

  logic rst_n_s;
  logic start, store;

  cmp_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cmp_seq_sched #(
    .GAP_TICKS   (GAP_TICKS),
    .STOP_CYCLES (STOP_CYCLES)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_sync (tick_sync),
    .tick_meas (tick_meas),
    .en        (en),
    .sel       (sel),
    .busy      (busy),
    .window    (det_window),
    .start     (start),
    .store     (store)
  );

  cmp_seq_result u_res (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .store    (store),
    .cmp_in   (cmp_in),
    .irq_mask (irq_mask),
    .result   (result),
    .irq      (irq)
  );

  // A running sequencer keeps the detector; an idle one follows the select bit
  assign det_route = busy | sel;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !det_window);

  assert_route_held_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy && $past(busy) && $fell(sel) |-> det_route);

endmodule

// File: tb/sim_cmp_meas_seq.sv
module sim_cmp_meas_seq;

  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rst_n, tick_sync, tick_meas, sel, en, irq_mask, cmp_in;
  logic result, busy, det_route, det_window, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // {cmp_in, expected irq} for each measurement of the main run
  localparam logic [1:0] VEC [0:6] = '{2'b10, 2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01};

  always #5 clk = ~clk;

  cmp_meas_seq #(.GAP_TICKS(GAP), .STOP_CYCLES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_sync(tick_sync), .tick_meas(tick_meas),
    .sel(sel), .en(en), .irq_mask(irq_mask), .cmp_in(cmp_in),
    .result(result), .busy(busy), .det_route(det_route),
    .det_window(det_window), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; spans one rising edge and returns at the next falling edge
  task automatic cyc(input logic s, input logic m);
    tick_sync = s;
    tick_meas = m;
    @(negedge clk);
    tick_sync = 1'b0;
    tick_meas = 1'b0;
  endtask

  // One full measurement: the gap ticks, then the latching tick
  task automatic do_meas(input logic c, input logic first, input logic exp_irq,
                         input logic exp_busy, input string tag);
    logic prev;
    prev   = result;
    cmp_in = c;
    if (!first) begin
      for (int k = 0; k < GAP - 1; k++) begin
        cyc(1'b0, 1'b1);
        chk("R4", {tag, " window during gap"}, det_window, (k == GAP - 2));
      end
      chk("R5", {tag, " result held before latch"}, result, prev);
    end
    cyc(1'b0, 1'b1);
    chk("R5", {tag, " latched result"}, result, c);
    chk("R7", {tag, " irq on latch"}, irq, exp_irq);
    chk("R6", {tag, " busy after latch"}, busy, exp_busy);
    cyc(1'b0, 1'b0);
    chk("R7", {tag, " irq one cycle"}, irq, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_sync = 1'b0; tick_meas = 1'b0;
    sel = 1'b0; en = 1'b0; irq_mask = 1'b1; cmp_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, R10 idle routing
    chk("R1", "result after reset", result, 1'b0);
    chk("R1", "busy after reset", busy, 1'b0);
    chk("R1", "window after reset", det_window, 1'b0);
    chk("R1", "irq after reset", irq, 1'b0);
    chk("R10", "route follows sel=0", det_route, 1'b0);

    // R2: enable without select never starts
    en = 1'b1;
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    chk("R2", "no start without select", busy, 1'b0);
    chk("R2", "no window without select", det_window, 1'b0);

    // R2 start, R3 synchronisation
    irq_mask = 1'b0;
    sel = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R2", "busy after start", busy, 1'b1);
    chk("R10", "route taken", det_route, 1'b1);
    cyc(1'b0, 1'b1);
    chk("R3", "meas tick ignored before sync", det_window, 1'b0);
    chk("R3", "result unchanged before sync", result, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R3", "window opens after sync", det_window, 1'b1);

    // Table walk: R4, R5, R7
    for (int i = 0; i < 7; i++) begin
      do_meas(VEC[i][1], (i == 0), VEC[i][0], 1'b1, "table");
    end

    // R8: masked pulse dropped, not held
    irq_mask = 1'b1;
    do_meas(1'b1, 1'b0, 1'b0, 1'b1, "masked");
    irq_mask = 1'b0;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R8", "no pending pulse after unmask", irq, 1'b0);
    do_meas(1'b1, 1'b0, 1'b0, 1'b1, "unmasked same");
    do_meas(1'b0, 1'b0, 1'b1, 1'b1, "unmasked change");

    // R9: select dropped while busy
    sel = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R9", "route held while busy", det_route, 1'b1);
    do_meas(1'b1, 1'b0, 1'b1, 1'b1, "sel dropped");

    // R6: cancelled stop
    en = 1'b0;
    do_meas(1'b1, 1'b0, 1'b0, 1'b1, "stop first");
    en = 1'b1;
    do_meas(1'b0, 1'b0, 1'b1, 1'b1, "after cancel");
    do_meas(1'b0, 1'b0, 1'b0, 1'b1, "after cancel 2");

    // R6: full graceful stop after two completions
    en = 1'b0;
    do_meas(1'b1, 1'b0, 1'b1, 1'b1, "stop current");
    do_meas(1'b0, 1'b0, 1'b1, 1'b0, "stop next");
    chk("R10", "route follows sel after stop", det_route, 1'b0);
    cmp_in = 1'b1;
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    chk("R5", "result held while idle", result, 1'b0);
    chk("R6", "stays idle", busy, 1'b0);

    // R2: re-enable with select low stays idle
    en = 1'b1;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R2", "no restart with sel low", busy, 1'b0);

    // R7: restart suppresses the first change pulse
    sel = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R2", "restart busy", busy, 1'b1);
    cyc(1'b1, 1'b0);
    chk("R3", "window after restart sync", det_window, 1'b1);
    do_meas(1'b1, 1'b1, 1'b0, 1'b1, "restart first");
    do_meas(1'b0, 1'b0, 1'b1, 1'b1, "restart second");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule